// File: doc/BRIEF.md
# Crossing-Ordered Trigger Decision Buffer

This block sits between a farm of trigger processors and the event buffer. Processors finish their Level-1 decisions in any order. Each decision carries the number of the beam crossing it belongs to. The block holds early decisions and hands them downstream strictly in crossing order. A crossing whose decision never shows up is not allowed to block the stream forever. Once every one of the 159 crossing numbers of a beam turn is outstanding, the oldest crossing is released as a timeout tag in its place.

A crossing strobe marks each new bunch crossing and issues the next crossing number, counting 0 to 158 and wrapping. The block does not store a decision that arrives for a crossing it has already released, or for a crossing it has not issued. The same holds for a crossing that already holds a decision and for a number outside the legal range. Each such decision is reported on a separate late output, so the downstream logic can mark it as unused at Level 1.

The ordered output uses a valid/ready handshake. While the receiver stalls, the head of the stream is held. If a new crossing strobe then finds every slot still outstanding, an overflow pulse is raised.

Top module: `rob_reorder`

## Requirements
- R1: After reset, accepted crossing strobes issue crossing numbers 0, 1, 2, … 158 and then wrap to 0. Every crossing number on any output except `late_xing` is in the range 0..158.
- R2: Released entries leave in strict issue order. The first entry after reset is crossing 0, and each later entry is the previous crossing plus one, modulo 159.
- R3: A decision for an issued, unreleased crossing that holds no decision yet is stored. It is presented with its payload and `out_timeout`=0 once it is at the head. The head is presented only when its decision is stored or it has timed out.
- R4: When all 159 crossings are outstanding and the head holds no decision, the head is presented with `out_timeout`=1 and `out_data`=0. With fewer than 159 outstanding, a head without a decision is not presented.
- R5: A decision is ignored and reported late one cycle later, with `late_valid`=1, `late_xing` set to its crossing and `late_bad`=0, in these cases: its crossing is not outstanding (released, or never issued), it is issued or released in the same cycle, or it already holds a decision. It leaves the stored payload unchanged.
- R6: A decision whose crossing number is 159 or above is never stored. One cycle later it is reported with `late_valid`=1, `late_bad`=1 and `late_xing` set to that number.
- R7: A crossing strobe that arrives while 159 crossings are outstanding and the head is not released in that cycle is dropped and issues no crossing. `ovf` pulses high for one cycle on the next cycle.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_xing` stay unchanged. Directly after reset, `out_valid`, `late_valid` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_stb | input | 1 | New bunch crossing: issue the next crossing number |
| dec_valid | input | 1 | A decision is present on the decision bus |
| dec_xing | input | 8 | Crossing number of the decision |
| dec_data | input | PW | Decision payload |
| out_ready | input | 1 | Downstream accepts the head entry |
| out_valid | output | 1 | Head entry is presented |
| out_xing | output | 8 | Crossing number of the head entry |
| out_data | output | PW | Payload of the head entry, 0 for a timeout tag |
| out_timeout | output | 1 | Head entry is a timeout tag, not a decision |
| late_valid | output | 1 | A decision was rejected in the previous cycle |
| late_xing | output | 8 | Crossing number of the rejected decision |
| late_bad | output | 1 | The rejected crossing number was out of range |
| ovf | output | 1 | A crossing strobe was dropped in the previous cycle |

## Verification
The ordered-output signals are driven combinationally from the stored state. A decision written at a clock edge therefore shows on `out_valid` during the next cycle, and a release at an edge moves the head during that same next cycle. The late report and the overflow pulse come from one register each, so they are due one cycle after the stimulus that caused them. The bench drives every input on the falling edge, reads the handshake outputs one nanosecond later in the same cycle, and reads the late and overflow outputs at the next falling edge, before it drives new inputs. A transaction-level model of the outstanding crossings in the bench predicts which decisions are stored, which are late, and when timeout tags must appear.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int XW = 8;
  typedef logic [XW-1:0] xing_t;

  // next crossing number in a turn of n crossings
  function automatic xing_t xing_step(xing_t p, int unsigned n);
    return (32'(p) == n - 1) ? '0 : p + 1'b1;
  endfunction

  // crossing number inside the turn
  function automatic logic xing_legal(xing_t x, int unsigned n);
    return 32'(x) < n;
  endfunction
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs
  import rob_pkg::*;
#(
  parameter int NSLOT = 159,
  localparam int CW = $clog2(NSLOT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          rel,
  output logic          take,
  output logic          full,
  output xing_t         wr_ptr,
  output xing_t         rd_ptr,
  output logic [CW-1:0] cnt
);
  assign full = (cnt == CW'(NSLOT));
  // a strobe is taken unless every slot is outstanding and none leaves now
  assign take = stb && (!full || rel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (take) wr_ptr <= xing_step(wr_ptr, NSLOT);
      if (rel)  rd_ptr <= xing_step(rd_ptr, NSLOT);
      case ({take, rel})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rob_slots.sv
module rob_slots
  import rob_pkg::*;
#(
  parameter int NSLOT = 159,
  parameter int PW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_en,
  input  xing_t            issue_idx,
  input  logic             rel_en,
  input  xing_t            rel_idx,
  input  logic             put_en,
  input  xing_t            put_idx,
  input  logic [PW-1:0]    put_data,
  input  xing_t            rd_idx,
  output logic [NSLOT-1:0] pend,
  output logic [NSLOT-1:0] pres,
  output logic [PW-1:0]    rd_data
);
  logic [PW-1:0] mem [NSLOT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      pres <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (rel_en && rel_idx == xing_t'(i)) begin
          pend[i] <= 1'b0;
          pres[i] <= 1'b0;
        end
        if (put_en && put_idx == xing_t'(i)) pres[i] <= 1'b1;
        // reissue wins: a full turn reuses the slot released this cycle
        if (issue_en && issue_idx == xing_t'(i)) begin
          pend[i] <= 1'b1;
          pres[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (put_en) mem[put_idx] <= put_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/rob_reorder.sv
module rob_reorder
  import rob_pkg::*;
#(
  parameter int NSLOT = 159,
  parameter int PW    = 8,
  localparam int CW   = $clog2(NSLOT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xing_stb,
  input  logic          dec_valid,
  input  logic [XW-1:0] dec_xing,
  input  logic [PW-1:0] dec_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [XW-1:0] out_xing,
  output logic [PW-1:0] out_data,
  output logic          out_timeout,
  output logic          late_valid,
  output logic [XW-1:0] late_xing,
  output logic          late_bad,
  output logic          ovf
);
  logic             take, full, rel, accept, legal, head_pres;
  xing_t            wr_ptr, rd_ptr, dec_idx;
  logic [CW-1:0]    cnt;
  logic [NSLOT-1:0] pend, pres;
  logic [PW-1:0]    head_data;

  rob_ptrs #(.NSLOT(NSLOT)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .stb(xing_stb), .rel(rel),
    .take(take), .full(full), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .cnt(cnt)
  );

  assign legal   = xing_legal(dec_xing, NSLOT);
  assign dec_idx = legal ? dec_xing : '0;

  assign head_pres = pres[rd_ptr];
  assign out_valid = (cnt != '0) && (head_pres || full);
  assign rel       = out_valid && out_ready;
  // stored only if outstanding, still empty, and not leaving this cycle
  assign accept    = dec_valid && legal && pend[dec_idx] && !pres[dec_idx]
                     && !(rel && rd_ptr == dec_idx);

  rob_slots #(.NSLOT(NSLOT), .PW(PW)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .issue_en(take), .issue_idx(wr_ptr),
    .rel_en(rel), .rel_idx(rd_ptr),
    .put_en(accept), .put_idx(dec_idx), .put_data(dec_data),
    .rd_idx(rd_ptr), .pend(pend), .pres(pres), .rd_data(head_data)
  );

  assign out_xing    = rd_ptr;
  assign out_timeout = !head_pres;
  assign out_data    = head_pres ? head_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      late_valid <= 1'b0;
      late_xing  <= '0;
      late_bad   <= 1'b0;
      ovf        <= 1'b0;
    end else begin
      late_valid <= dec_valid && !accept;
      late_xing  <= dec_xing;
      late_bad   <= dec_valid && !legal;
      ovf        <= xing_stb && !take;
    end
  end
endmodule

// File: rtl/rob_chk.sv
module rob_chk
  import rob_pkg::*;
#(
  parameter int NSLOT = 159,
  parameter int PW    = 8,
  localparam int CW   = $clog2(NSLOT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [XW-1:0] out_xing,
  input logic          out_timeout,
  input logic [PW-1:0] out_data,
  input logic [CW-1:0] cnt,
  input logic          late_valid,
  input logic          late_bad,
  input logic [XW-1:0] late_xing,
  input logic          ovf
);
  AST_XING_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> xing_legal(out_xing, NSLOT)); // R1
  AST_STRICT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (out_xing == xing_step($past(out_xing), NSLOT))); // R2
  AST_TAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_timeout) |-> (out_data == '0)); // R4
  AST_TAG_FULL_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_timeout) |-> (cnt == CW'(NSLOT))); // R4
  AST_BAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (late_valid && late_bad) |-> !xing_legal(late_xing, NSLOT)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(!out_ready)); // R7
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_xing))); // R8
endmodule

bind rob_reorder rob_chk #(.NSLOT(NSLOT), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_xing(out_xing), .out_timeout(out_timeout), .out_data(out_data),
  .cnt(cnt), .late_valid(late_valid), .late_bad(late_bad),
  .late_xing(late_xing), .ovf(ovf)
);

// File: tb/tb_rob_reorder.sv
module tb_rob_reorder;
  localparam int N = 159;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xing_stb = 0, dec_valid = 0, out_ready = 0;
  logic [7:0] dec_xing = 0, dec_data = 0;
  logic out_valid, out_timeout, late_valid, late_bad, ovf;
  logic [7:0] out_xing, out_data, late_xing;

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  rob_reorder dut (
    .clk(clk), .rst_n(rst_n), .xing_stb(xing_stb), .dec_valid(dec_valid),
    .dec_xing(dec_xing), .dec_data(dec_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_xing(out_xing), .out_data(out_data),
    .out_timeout(out_timeout), .late_valid(late_valid), .late_xing(late_xing),
    .late_bad(late_bad), .ovf(ovf)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       stb, dv; logic [7:0] dx, dd; logic rdy;
    logic       ov; logic [7:0] ox, od; logic to;
    logic       lv; logic [7:0] lx; logic lb;
  } vec_t;

  // row: stimulus, then head expected before the edge, then late report after it
  localparam vec_t TAB [10] = '{
    '{1'b1,1'b0,8'd0,  8'h00,1'b0, 1'b0,8'd0,8'h00,1'b0, 1'b0,8'd0,  1'b0},
    '{1'b1,1'b1,8'd1,  8'h55,1'b0, 1'b0,8'd0,8'h00,1'b0, 1'b1,8'd1,  1'b0},
    '{1'b0,1'b1,8'd1,  8'h11,1'b0, 1'b0,8'd0,8'h00,1'b0, 1'b0,8'd0,  1'b0},
    '{1'b0,1'b1,8'd1,  8'h77,1'b0, 1'b0,8'd0,8'h00,1'b0, 1'b1,8'd1,  1'b0},
    '{1'b0,1'b1,8'd0,  8'h22,1'b0, 1'b0,8'd0,8'h00,1'b0, 1'b0,8'd0,  1'b0},
    '{1'b0,1'b0,8'd0,  8'h00,1'b0, 1'b1,8'd0,8'h22,1'b0, 1'b0,8'd0,  1'b0},
    '{1'b0,1'b0,8'd0,  8'h00,1'b1, 1'b1,8'd0,8'h22,1'b0, 1'b0,8'd0,  1'b0},
    '{1'b0,1'b1,8'd0,  8'h33,1'b1, 1'b1,8'd1,8'h11,1'b0, 1'b1,8'd0,  1'b0},
    '{1'b0,1'b1,8'd200,8'h44,1'b1, 1'b0,8'd0,8'h00,1'b0, 1'b1,8'd200,1'b1},
    '{1'b0,1'b1,8'd1,  8'h66,1'b1, 1'b0,8'd0,8'h00,1'b0, 1'b1,8'd1,  1'b0}
  };

  task automatic drive(logic s, logic v, logic [7:0] x, logic [7:0] d, logic r);
    xing_stb = s; dec_valid = v; dec_xing = x; dec_data = d; out_ready = r;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // transaction-level model state for the random phase
  bit outst [N]; bit got [N]; bit sched [N];
  int due [N]; logic [7:0] bdat [N]; logic [7:0] sdat [N];

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int bw, brd, nout, lx_exp;
    bit lv_exp, fire;
    do_reset();
    @(negedge clk); #1;
    check("R8 reset out_valid", out_valid, 0);
    check("R8 reset late_valid", late_valid, 0);
    check("R8 reset ovf", ovf, 0);

    // table walk (R1 R2 R3 R5 R6)
    foreach (TAB[i]) begin
      drive(TAB[i].stb, TAB[i].dv, TAB[i].dx, TAB[i].dd, TAB[i].rdy);
      #1;
      check($sformatf("R3 row%0d out_valid", i), out_valid, TAB[i].ov);
      if (TAB[i].ov) begin
        check($sformatf("R2 row%0d out_xing", i), out_xing, TAB[i].ox);
        check($sformatf("R3 row%0d out_data", i), out_data, TAB[i].od);
        check($sformatf("R3 row%0d out_timeout", i), out_timeout, TAB[i].to);
      end
      @(negedge clk);
      check($sformatf("R5 row%0d late_valid", i), late_valid, TAB[i].lv);
      if (TAB[i].lv) begin
        check($sformatf("R5 row%0d late_xing", i), late_xing, TAB[i].lx);
        check($sformatf("R6 row%0d late_bad", i), late_bad, TAB[i].lb);
      end
    end

    // timeout and overflow: next crossing to issue is 2, none outstanding
    for (int k = 0; k < 158; k++) begin
      drive(1, 0, 0, 0, 0);
      @(negedge clk);
    end
    drive(0, 0, 0, 0, 0); #1;
    check("R4 no tag before full turn", out_valid, 0);
    drive(1, 0, 0, 0, 0);
    @(negedge clk); #1;
    check("R4 tag valid", out_valid, 1);
    check("R4 tag flag", out_timeout, 1);
    check("R4 tag xing", out_xing, 2);
    check("R4 tag data", out_data, 0);
    drive(1, 0, 0, 0, 0);
    @(negedge clk);
    check("R7 ovf pulse", ovf, 1);
    drive(0, 0, 0, 0, 1); #1;
    check("R8 head held", out_xing, 2);
    @(negedge clk); #1;
    check("R7 ovf one cycle", ovf, 0);
    check("R4 head not full", out_valid, 0);
    drive(1, 0, 0, 0, 1);
    @(negedge clk); #1;
    check("R7 dropped strobe, turn full again", out_valid, 1);
    check("R4 next tag xing", out_xing, 3);
    check("R4 next tag flag", out_timeout, 1);

    // random latencies up to and beyond one turn
    do_reset();
    bw = 0; brd = 0; nout = 0; lv_exp = 0; lx_exp = 0;
    for (int x = 0; x < N; x++) begin outst[x] = 0; got[x] = 0; sched[x] = 0; end
    for (int cyc = 0; cyc < 20000; cyc++) begin
      logic s, v, r; logic [7:0] dx, dd;
      bit acc;
      @(negedge clk);
      check("R5 late_valid", late_valid, lv_exp);
      if (lv_exp) begin
        check("R5 late_xing", late_xing, lx_exp);
        check("R6 late_bad", late_bad, (lx_exp >= N) ? 1 : 0);
      end
      check("R7 no ovf when strobes follow ready", ovf, 0);
      r = ($urandom % 4) != 0;
      s = r && ($urandom % 3 == 0);
      v = 0; dx = 0; dd = 8'($urandom);
      if ($urandom % 200 == 0) begin
        v = 1; dx = 8'(N + ($urandom % 97));
      end else begin
        for (int x = 0; x < N; x++)
          if (!v && sched[x] && due[x] <= cyc) begin
            v = 1; dx = 8'(x); dd = sdat[x]; sched[x] = 0;
          end
      end
      drive(s, v, dx, dd, r);
      #1;
      check("R3 head presented", out_valid,
            (nout > 0 && (got[brd] || nout == N)) ? 1 : 0);
      fire = out_valid && out_ready;
      acc = v && (dx < N) && outst[dx] && !got[dx] && !(fire && dx == brd);
      if (fire) begin
        check("R2 strict order", out_xing, brd);
        check("R4 tag only without decision", out_timeout, got[brd] ? 0 : 1);
        if (out_timeout) check("R4 tag after full turn", nout, N);
        else check("R3 payload", out_data, bdat[brd]);
        outst[brd] = 0; got[brd] = 0; nout--;
        brd = (brd == N - 1) ? 0 : brd + 1;
      end
      if (acc) begin got[dx] = 1; bdat[dx] = dd; end
      lv_exp = v && !acc; lx_exp = dx;
      if (s) begin
        outst[bw] = 1; got[bw] = 0; nout++;
        sched[bw] = ($urandom % 10) != 0;
        due[bw] = cyc + 1 + ($urandom % 700);
        sdat[bw] = 8'($urandom);
        bw = (bw == N - 1) ? 0 : bw + 1;
      end
    end
    @(negedge clk);
    check("R5 final late_valid", late_valid, lv_exp);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule